// File: doc/BRIEF.md
# Predicated SIMD Lane Array

This block is a row of identical processing lanes driven by one instruction stream. Each accepted instruction goes to every lane in the same clock cycle. Each lane owns a small register file, a private data memory and a one-bit condition flag. Each lane is joined in a ring to the lanes on its left and right. Either source operand of an instruction can be read from the local register file or from the same-numbered register of a ring neighbour. Lane `i` has left neighbour `(i-1) mod N` and right neighbour `(i+1) mod N`. All neighbour values are the ones held before the instruction executes, so a ring-wide shift is consistent.

Every instruction carries a predicate. A lane runs the instruction only when the predicate is off, or when the lane's flag equals the predicate value. Otherwise the lane leaves its registers, flag and memory untouched. The compare operation writes the flag, and it is predicated too, so nested conditions can be narrowed step by step.

Instructions enter through a valid/ready handshake. A separate write port fills any lane's memory. A combinational debug port reads any register or flag of any lane.

Top module: `simd_pe_array`

## Requirements
- R1: The operation codes are add=0, subtract=1, and=2, or=3, xor=4. For these, every executing lane writes A op B into its destination register. The result is visible at the debug port after the clock edge that accepts the instruction. Subtraction wraps modulo 2^DATA_W.
- R2: The predicate field has bit 1 = enable and bit 0 = value. With enable 0, every lane executes. With enable 1, only lanes whose flag equals the value execute. The other lanes keep their registers, flag and memory unchanged.
- R3: Compare (code 7) sets the flag to 1 when A < B unsigned and to 0 otherwise. It obeys the predicate, so a lane with a non-matching flag keeps its flag. No other operation changes the flag.
- R4: Each source has a 2-bit selector: 0 = own register file, 1 = left neighbour, 2 = right neighbour, 3 = own register file. The ring wraps, so lane 0's left neighbour is lane N-1. Neighbour reads return the values held before the current instruction.
- R5: Load (code 5) writes mem[B mod MEM_DEPTH] into the destination register. The value is visible from the second clock edge after acceptance. in_ready is low for exactly the one cycle after a load is accepted. An instruction held valid during that cycle is accepted once, afterwards.
- R6: Store (code 6) writes A into mem[B mod MEM_DEPTH] of each executing lane.
- R7: When ld_we is high, ld_data is written to mem[ld_addr] of lane ld_pe at the clock edge. If a lane executes a store to the same address in that cycle, the store value is kept. A port write to a different address lands alongside the store.
- R8: After reset, all registers are zero, all flags are zero and in_ready is high.
- R9: Operation codes 8 to 15 change no register, flag or memory location in any lane.
- R10: dbg_data and dbg_flag show register dbg_reg and the flag of lane dbg_pe in the same cycle, without a clock edge.
- R11: Instruction fields, from LSB upward, are laid out as follows: B register index, B selector, A register index, A selector, destination index, 4-bit operation code, and 2-bit predicate at the top. Each register index is log2(NUM_REG) bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Array can accept an instruction |
| in_instr | input | 3*log2(NUM_REG)+10 | Broadcast instruction word |
| ld_we | input | 1 | Memory fill write enable |
| ld_pe | input | log2(NUM_PE) | Lane selected for the fill write |
| ld_addr | input | log2(MEM_DEPTH) | Fill write address |
| ld_data | input | DATA_W | Fill write data |
| dbg_pe | input | log2(NUM_PE) | Lane selected for debug read |
| dbg_reg | input | log2(NUM_REG) | Register selected for debug read |
| dbg_data | output | DATA_W | Selected register value |
| dbg_flag | output | 1 | Flag of the selected lane |

## Verification
Two writes can hit one lane's memory in the same cycle: a broadcast store executed by the lane, and a fill-port write. The bench drives the port toward one lane in the very cycle a store is accepted. It does this once at the store's address and once at a different address. It then loads both locations back through the instruction path. The same-address case must return the stored operand. The different-address case must return both the port value and the store value.

// File: rtl/simd_pkg.sv
package simd_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_AND = 4'd2,
      OP_OR  = 4'd3,
      OP_XOR = 4'd4,
      OP_LD  = 4'd5,
      OP_ST  = 4'd6,
      OP_CMP = 4'd7
   } op_e;

   typedef enum logic [1:0] {
      SRC_OWN   = 2'd0,
      SRC_LEFT  = 2'd1,
      SRC_RIGHT = 2'd2,
      SRC_OWN_B = 2'd3
   } src_e;

   typedef struct packed {
      logic pred_on;
      logic pred_val;
      op_e  op;
      src_e sel_a;
      src_e sel_b;
   } ctl_t;

   function automatic logic is_arith(op_e op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
             (op == OP_OR)  || (op == OP_XOR);
   endfunction

endpackage

// File: rtl/simd_issue.sv
module simd_issue (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic is_load,
   output logic in_ready,
   output logic fire
);

   logic stall_q;

   assign in_ready = !stall_q;
   assign fire     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) stall_q <= 1'b0;
      else        stall_q <= fire && is_load;
   end

   // R5: a load acceptance drops ready in the following cycle
   a_r5_stall_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && is_load) |=> !in_ready);

   // R5: the stall never lasts more than one cycle
   a_r5_stall_single: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |=> in_ready);

endmodule

// File: rtl/simd_alu.sv
module simd_alu
   import simd_pkg::*;
#(
   parameter int W = 16
) (
   input  op_e          op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y,
   output logic         lt
);

   always_comb begin
      unique case (op)
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         default: y = a;
      endcase
   end

   assign lt = (a < b);

endmodule

// File: rtl/simd_pe.sv
module simd_pe
   import simd_pkg::*;
#(
   parameter  int W     = 16,
   parameter  int NREG  = 8,
   parameter  int DEPTH = 16,
   localparam int RAW   = $clog2(NREG),
   localparam int MAW   = $clog2(DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           fire,
   input  ctl_t           ctl,
   input  logic [RAW-1:0] dst,
   input  logic [RAW-1:0] ra,
   input  logic [RAW-1:0] rb,
   input  logic [W-1:0]   left_a,
   input  logic [W-1:0]   left_b,
   input  logic [W-1:0]   right_a,
   input  logic [W-1:0]   right_b,
   input  logic           port_we,
   input  logic [MAW-1:0] port_addr,
   input  logic [W-1:0]   port_data,
   input  logic [RAW-1:0] dbg_reg,
   output logic [W-1:0]   own_a,
   output logic [W-1:0]   own_b,
   output logic [W-1:0]   dbg_val,
   output logic           flag
);

   logic [W-1:0]      rf  [NREG];
   logic [W-1:0]      mem [DEPTH];
   logic              flag_q;
   logic              ld_pend;
   logic [RAW-1:0]    ld_dst;
   logic [W-1:0]      ld_q;
   logic [W-1:0]      opa, opb, alu_y;
   logic              alu_lt;
   logic              exec, arith_go, ld_go, st_go, cmp_go;
   logic [MAW-1:0]    mem_addr;
   logic [NREG*W-1:0] rf_flat;

   assign own_a   = rf[ra];
   assign own_b   = rf[rb];
   assign dbg_val = rf[dbg_reg];
   assign flag    = flag_q;

   always_comb begin
      unique case (ctl.sel_a)
         SRC_LEFT:  opa = left_a;
         SRC_RIGHT: opa = right_a;
         default:   opa = own_a;
      endcase
      unique case (ctl.sel_b)
         SRC_LEFT:  opb = left_b;
         SRC_RIGHT: opb = right_b;
         default:   opb = own_b;
      endcase
   end

   assign exec     = fire && (!ctl.pred_on || (flag_q == ctl.pred_val));
   assign arith_go = exec && is_arith(ctl.op);
   assign ld_go    = exec && (ctl.op == OP_LD);
   assign st_go    = exec && (ctl.op == OP_ST);
   assign cmp_go   = exec && (ctl.op == OP_CMP);
   assign mem_addr = opb[MAW-1:0];

   simd_alu #(.W(W)) u_alu (
      .op (ctl.op),
      .a  (opa),
      .b  (opb),
      .y  (alu_y),
      .lt (alu_lt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) rf[i] <= '0;
      end else begin
         if (arith_go) rf[dst]    <= alu_y;
         if (ld_pend)  rf[ld_dst] <= ld_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         ld_pend <= 1'b0;
         ld_dst  <= '0;
      end else begin
         if (cmp_go) flag_q <= alu_lt;
         ld_pend <= ld_go;
         if (ld_go) ld_dst <= dst;
      end
   end

   // memory: fill port first, broadcast store last so the store wins
   always_ff @(posedge clk) begin
      if (port_we) mem[port_addr] <= port_data;
      if (st_go)   mem[mem_addr]  <= opa;
      ld_q <= mem[mem_addr];
   end

   always_comb begin
      for (int i = 0; i < NREG; i++) rf_flat[i*W +: W] = rf[i];
   end

   // R2: a lane whose flag mismatches keeps its registers and flag
   a_r2_masked_lane_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && ctl.pred_on && (flag_q != ctl.pred_val)) |=> ($stable(rf_flat) && $stable(flag_q)));

   // R3: only an accepted compare can move the flag
   a_r3_flag_only_by_compare: assert property (@(posedge clk) disable iff (!rst_n)
      !(fire && (ctl.op == OP_CMP)) |=> $stable(flag_q));

   // R9: with no arithmetic op accepted and no load returning, registers hold
   a_r9_regs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((!fire || !is_arith(ctl.op)) && !ld_pend) |=> $stable(rf_flat));

   // R6/R7: an executed store lands, even against a fill write to that address
   a_r7_store_beats_port: assert property (@(posedge clk) disable iff (!rst_n)
      st_go |=> (mem[$past(mem_addr)] == $past(opa)));

endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array
   import simd_pkg::*;
#(
   parameter  int NUM_PE    = 8,
   parameter  int DATA_W    = 16,
   parameter  int NUM_REG   = 8,
   parameter  int MEM_DEPTH = 16,
   localparam int RAW       = $clog2(NUM_REG),
   localparam int MAW       = $clog2(MEM_DEPTH),
   localparam int PAW       = $clog2(NUM_PE),
   localparam int INSTR_W   = 3*RAW + 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [INSTR_W-1:0] in_instr,
   input  logic               ld_we,
   input  logic [PAW-1:0]     ld_pe,
   input  logic [MAW-1:0]     ld_addr,
   input  logic [DATA_W-1:0]  ld_data,
   input  logic [PAW-1:0]     dbg_pe,
   input  logic [RAW-1:0]     dbg_reg,
   output logic [DATA_W-1:0]  dbg_data,
   output logic               dbg_flag
);

   // field positions (R11)
   localparam int B_LO   = 0;
   localparam int SB_LO  = RAW;
   localparam int A_LO   = RAW + 2;
   localparam int SA_LO  = 2*RAW + 2;
   localparam int D_LO   = 2*RAW + 4;
   localparam int OP_LO  = 3*RAW + 4;
   localparam int PR_LO  = 3*RAW + 8;

   if (NUM_PE < 2) begin : g_bad_pe
      $error("simd_pe_array: NUM_PE must be at least 2");
   end
   if ((NUM_REG < 2) || ((1 << RAW) != NUM_REG)) begin : g_bad_reg
      $error("simd_pe_array: NUM_REG must be a power of two, at least 2");
   end
   if ((MEM_DEPTH < 2) || ((1 << MAW) != MEM_DEPTH)) begin : g_bad_mem
      $error("simd_pe_array: MEM_DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < MAW) begin : g_bad_w
      $error("simd_pe_array: DATA_W too narrow to address local memory");
   end

   ctl_t           ctl;
   logic [RAW-1:0] f_dst, f_ra, f_rb;
   logic           fire;

   always_comb begin
      ctl.pred_on  = in_instr[PR_LO+1];
      ctl.pred_val = in_instr[PR_LO];
      ctl.op       = op_e'(in_instr[OP_LO +: 4]);
      ctl.sel_a    = src_e'(in_instr[SA_LO +: 2]);
      ctl.sel_b    = src_e'(in_instr[SB_LO +: 2]);
   end
   assign f_dst = in_instr[D_LO +: RAW];
   assign f_ra  = in_instr[A_LO +: RAW];
   assign f_rb  = in_instr[B_LO +: RAW];

   simd_issue u_issue (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .is_load  (ctl.op == OP_LD),
      .in_ready (in_ready),
      .fire     (fire)
   );

   logic [DATA_W-1:0] lane_a   [NUM_PE];
   logic [DATA_W-1:0] lane_b   [NUM_PE];
   logic [DATA_W-1:0] lane_dbg [NUM_PE];
   logic              lane_flag[NUM_PE];

   for (genvar g = 0; g < NUM_PE; g++) begin : g_lane
      localparam int LEFT  = (g + NUM_PE - 1) % NUM_PE;
      localparam int RIGHT = (g + 1) % NUM_PE;

      simd_pe #(
         .W     (DATA_W),
         .NREG  (NUM_REG),
         .DEPTH (MEM_DEPTH)
      ) u_pe (
         .clk       (clk),
         .rst_n     (rst_n),
         .fire      (fire),
         .ctl       (ctl),
         .dst       (f_dst),
         .ra        (f_ra),
         .rb        (f_rb),
         .left_a    (lane_a[LEFT]),
         .left_b    (lane_b[LEFT]),
         .right_a   (lane_a[RIGHT]),
         .right_b   (lane_b[RIGHT]),
         .port_we   (ld_we && (ld_pe == PAW'(g))),
         .port_addr (ld_addr),
         .port_data (ld_data),
         .dbg_reg   (dbg_reg),
         .own_a     (lane_a[g]),
         .own_b     (lane_b[g]),
         .dbg_val   (lane_dbg[g]),
         .flag      (lane_flag[g])
      );
   end

   always_comb begin
      dbg_data = '0;
      dbg_flag = 1'b0;
      for (int i = 0; i < NUM_PE; i++) begin
         if (dbg_pe == PAW'(i)) begin
            dbg_data = lane_dbg[i];
            dbg_flag = lane_flag[i];
         end
      end
   end

   // R8: ready is high in the first cycle after reset
   a_r8_ready_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> in_ready);

endmodule

// File: tb/simd_pe_array_test.sv
module simd_pe_array_test;
   import simd_pkg::*;

   localparam int NP = 8;
   localparam int W  = 16;
   localparam int NR = 8;
   localparam int MD = 16;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic        in_ready;
   logic [18:0] in_instr;
   logic        ld_we;
   logic [2:0]  ld_pe;
   logic [3:0]  ld_addr;
   logic [15:0] ld_data;
   logic [2:0]  dbg_pe;
   logic [2:0]  dbg_reg;
   logic [15:0] dbg_data;
   logic        dbg_flag;

   always #5 clk = ~clk;

   simd_pe_array uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_instr(in_instr), .ld_we(ld_we), .ld_pe(ld_pe), .ld_addr(ld_addr),
      .ld_data(ld_data), .dbg_pe(dbg_pe), .dbg_reg(dbg_reg),
      .dbg_data(dbg_data), .dbg_flag(dbg_flag)
   );

   int errors = 0;
   int checks = 0;

   // reference state built from the requirements
   logic [15:0] m_rf  [NP][NR];
   logic        m_flag[NP];
   logic [15:0] m_mem [NP][MD];

   typedef struct {
      int          pe;
      int          idx;
      bit          is_flag;
      logic [15:0] exp;
      string       tag;
   } item_t;
   item_t sbq[$];

   task automatic note(bit ok, string tag, string what, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // monitor: pops expected items and compares against the debug port
   initial begin
      item_t it;
      dbg_pe  = '0;
      dbg_reg = '0;
      forever begin
         wait (sbq.size() != 0);
         @(negedge clk);
         it      = sbq[0];
         dbg_pe  = it.pe[2:0];
         dbg_reg = it.idx[2:0];
         #1;
         if (it.is_flag)
            note(dbg_flag === it.exp[0], it.tag, $sformatf("lane%0d flag", it.pe),
                 {15'd0, dbg_flag}, it.exp);
         else
            note(dbg_data === it.exp, it.tag, $sformatf("lane%0d r%0d", it.pe, it.idx),
                 dbg_data, it.exp);
         void'(sbq.pop_front());
      end
   end

   task automatic push_reg(int pe, int r, string tag);
      item_t it;
      it.pe = pe; it.idx = r; it.is_flag = 1'b0; it.exp = m_rf[pe][r]; it.tag = tag;
      sbq.push_back(it);
   endtask

   task automatic push_flag(int pe, string tag);
      item_t it;
      it.pe = pe; it.idx = 0; it.is_flag = 1'b1; it.exp = {15'd0, m_flag[pe]}; it.tag = tag;
      sbq.push_back(it);
   endtask

   task automatic push_reg_all(int r, string tag);
      for (int p = 0; p < NP; p++) push_reg(p, r, tag);
   endtask

   task automatic push_flag_all(string tag);
      for (int p = 0; p < NP; p++) push_flag(p, tag);
   endtask

   task automatic drain();
      wait (sbq.size() == 0);
      @(negedge clk);
   endtask

   function automatic logic [18:0] mk(logic [1:0] pred, logic [3:0] op, int dst,
                                      logic [1:0] sa, int ra, logic [1:0] sb, int rb);
      return {pred, op, dst[2:0], sa, ra[2:0], sb, rb[2:0]};
   endfunction

   task automatic model(logic [18:0] w, bit pen, int ppe, int paddr, logic [15:0] pdata);
      logic [15:0] orf [NP][NR];
      logic [15:0] omem[NP][MD];
      logic [15:0] a, b;
      bit          ex;
      orf  = m_rf;
      omem = m_mem;
      if (pen) m_mem[ppe][paddr] = pdata;
      for (int p = 0; p < NP; p++) begin
         int lp = (p + NP - 1) % NP;
         int rp = (p + 1) % NP;
         a = (w[9:8] == 2'd1) ? orf[lp][w[7:5]] : (w[9:8] == 2'd2) ? orf[rp][w[7:5]] : orf[p][w[7:5]];
         b = (w[4:3] == 2'd1) ? orf[lp][w[2:0]] : (w[4:3] == 2'd2) ? orf[rp][w[2:0]] : orf[p][w[2:0]];
         ex = !w[18] || (m_flag[p] == w[17]);
         if (ex) begin
            case (w[16:13])
               4'd0: m_rf[p][w[12:10]] = a + b;
               4'd1: m_rf[p][w[12:10]] = a - b;
               4'd2: m_rf[p][w[12:10]] = a & b;
               4'd3: m_rf[p][w[12:10]] = a | b;
               4'd4: m_rf[p][w[12:10]] = a ^ b;
               4'd5: m_rf[p][w[12:10]] = omem[p][b[3:0]];
               4'd6: m_mem[p][b[3:0]] = a;
               4'd7: m_flag[p] = (a < b);
               default: ;
            endcase
         end
      end
   endtask

   // driver: caller stands at a falling edge
   task automatic issue(logic [18:0] w, bit pen = 1'b0, int ppe = 0, int paddr = 0,
                        logic [15:0] pdata = '0);
      in_valid = 1'b1;
      in_instr = w;
      ld_we    = pen;
      ld_pe    = ppe[2:0];
      ld_addr  = paddr[3:0];
      ld_data  = pdata;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      model(w, pen, ppe, paddr, pdata);
      @(negedge clk);
      in_valid = 1'b0;
      ld_we    = 1'b0;
      if (w[16:13] == 4'd5)
         note(in_ready === 1'b0, "R5", "ready one cycle after load", {15'd0, in_ready}, 16'd0);
   endtask

   task automatic port_write(int pe, int addr, logic [15:0] data);
      ld_we   = 1'b1;
      ld_pe   = pe[2:0];
      ld_addr = addr[3:0];
      ld_data = data;
      @(posedge clk);
      m_mem[pe][addr] = data;
      @(negedge clk);
      ld_we = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_instr = '0;
      ld_we    = 1'b0;
      ld_pe    = '0;
      ld_addr  = '0;
      ld_data  = '0;
      for (int p = 0; p < NP; p++) begin
         m_flag[p] = 1'b0;
         for (int r = 0; r < NR; r++) m_rf[p][r] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R8: reset state
      note(in_ready === 1'b1, "R8", "ready after reset", {15'd0, in_ready}, 16'd1);
      for (int r = 0; r < NR; r++) push_reg_all(r, "R8");
      push_flag_all("R8");
      drain();

      // fill memories through the port (R7)
      for (int p = 0; p < NP; p++) begin
         port_write(p, 0, 16'd1);
         port_write(p, 1, 16'(p + 1));
         port_write(p, 2, 16'(10 * p + 3));
      end

      // R5: loads; second load follows back to back and waits out the stall
      issue(mk(2'b00, OP_LD, 1, 2'd0, 0, 2'd0, 0));
      issue(mk(2'b00, OP_LD, 2, 2'd0, 0, 2'd0, 1));
      issue(mk(2'b00, OP_ADD, 3, 2'd0, 1, 2'd0, 1));
      issue(mk(2'b00, OP_LD, 4, 2'd0, 0, 2'd0, 3));
      push_reg_all(1, "R5");
      push_reg_all(2, "R5");
      push_reg_all(4, "R5");
      push_reg_all(3, "R1 add");
      drain();

      // R1: arithmetic and logic operations, R10 debug read
      issue(mk(2'b00, OP_SUB, 6, 2'd0, 2, 2'd0, 4));
      push_reg_all(6, "R1 sub wrap");
      drain();
      issue(mk(2'b00, OP_AND, 7, 2'd0, 2, 2'd0, 4));
      issue(mk(2'b00, OP_OR,  5, 2'd0, 7, 2'd0, 6));
      issue(mk(2'b00, OP_XOR, 6, 2'd0, 6, 2'd0, 2));
      push_reg_all(7, "R1 and");
      push_reg_all(5, "R1 or");
      push_reg_all(6, "R10 xor via debug");
      drain();

      // R4: neighbour operands, wrap at the ring ends, selector 3 is local
      issue(mk(2'b00, OP_ADD, 5, 2'd1, 2, 2'd2, 4));
      push_reg_all(5, "R4 left+right");
      drain();
      issue(mk(2'b00, OP_ADD, 7, 2'd3, 4, 2'd2, 0));
      push_reg_all(7, "R4 sel3 local");
      drain();
      issue(mk(2'b00, OP_ADD, 2, 2'd1, 2, 2'd0, 0));
      push_reg_all(2, "R4 ring shift");
      drain();

      // R3: compare, unpredicated
      issue(mk(2'b00, OP_ADD, 6, 2'd0, 3, 2'd0, 3));
      issue(mk(2'b00, OP_CMP, 0, 2'd0, 2, 2'd0, 6));
      push_flag_all("R3 compare");
      drain();

      // R2: predicated execution on both flag values
      issue(mk(2'b11, OP_ADD, 7, 2'd0, 4, 2'd0, 4));
      push_reg_all(7, "R2 pred=1");
      drain();
      issue(mk(2'b10, OP_XOR, 7, 2'd0, 7, 2'd0, 4));
      push_reg_all(7, "R2 pred=0");
      drain();

      // R3: nested compare, only lanes with flag 1 re-evaluate
      issue(mk(2'b11, OP_CMP, 0, 2'd0, 1, 2'd0, 2));
      push_flag_all("R3 nested");
      drain();

      // R9: undefined operation code changes nothing
      issue(mk(2'b00, 4'd9, 5, 2'd0, 4, 2'd0, 4));
      issue(mk(2'b00, 4'd15, 7, 2'd0, 4, 2'd0, 6));
      push_reg_all(5, "R9");
      push_reg_all(7, "R9");
      push_flag_all("R9");
      drain();

      // R6: store then load back (address 4 in r6)
      issue(mk(2'b00, OP_ST, 0, 2'd0, 5, 2'd0, 6));
      issue(mk(2'b00, OP_LD, 7, 2'd0, 0, 2'd0, 6));
      push_reg_all(7, "R6");
      drain();

      // R7: fill write and store to the same address in one cycle
      issue(mk(2'b00, OP_ST, 0, 2'd0, 2, 2'd0, 6), 1'b1, 3, 4, 16'hBEEF);
      issue(mk(2'b00, OP_LD, 7, 2'd0, 0, 2'd0, 6));
      push_reg_all(7, "R7 store wins");
      drain();

      // R7: fill write alone lands
      port_write(3, 4, 16'h1234);
      issue(mk(2'b00, OP_LD, 7, 2'd0, 0, 2'd0, 6));
      push_reg(3, 7, "R7 port alone");
      drain();

      // R7: fill write to another address alongside a store
      issue(mk(2'b00, OP_ADD, 0, 2'd0, 1, 2'd0, 6));
      issue(mk(2'b00, OP_ST, 0, 2'd0, 4, 2'd0, 6), 1'b1, 5, 5, 16'h5A5A);
      issue(mk(2'b00, OP_LD, 7, 2'd0, 0, 2'd0, 0));
      issue(mk(2'b00, OP_LD, 5, 2'd0, 0, 2'd0, 6));
      push_reg(5, 7, "R7 port other addr");
      push_reg_all(5, "R7 store alongside");
      drain();

      // R11: field layout exercised with the highest register indices
      issue(mk(2'b00, OP_ADD, 7, 2'd0, 7, 2'd0, 7));
      push_reg_all(7, "R11");
      drain();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule